// File: doc/BRIEF.md
# Write protection command sequencer

This block sits ahead of the write path of a byte-alterable nonvolatile memory and decides, for every qualified write strobe, whether the write may reach the page buffer. It watches the address and data of each strobe for two fixed command sequences. The three-write arming sequence switches protection on and opens exactly one page-load window. The six-write disarming sequence switches protection off once the following programming cycle has ended. While protection is on, any write that does not come inside an opened window is discarded.

The protection flag models a nonvolatile bit. Only the power-on reset clears it; the functional reset leaves it alone. The writes that form a command never reach the page buffer. Each step of a command must follow the previous step within a bounded number of idle cycles, or the sequence is forgotten. A write that breaks a sequence returns the matcher to idle and is treated as an ordinary write. The write path pulses `loadDone` when a page load and its programming cycle have finished.

Top module: `wprot_seq`

## Requirements
- R1: After a power-on reset (`porN` low), `protOn` is 0. While `protOn` is 0, every strobe that is not a matching command step gives `wrPermit` = 1 in the same cycle as `wrStb`. `wrPermit` is never 1 without `wrStb`.
- R2: The arming sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of these three strobes is permitted. `protOn` reads 1 from the cycle after the third write, whatever its earlier value.
- R3: After arming, a load window is open. Up to PAGE_BYTES strobes are permitted. Every further strobe in the window is dropped.
- R4: A `loadDone` pulse closes the window. `protOn` stays 1.
- R5: While `protOn` is 1 and no window is open, every strobe is dropped. A strobe that does not match the expected step sends the matcher back to idle, so the remaining steps of an interrupted sequence do not open a window.
- R6: The disarming sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. None of its strobes is permitted. `protOn` stays 1 until the next `loadDone` and reads 0 from the cycle after it.
- R7: The functional reset (`rstN` low) does not change `protOn`.
- R8: After a matched step, up to STEP_WIN-1 idle cycles may pass before the next step. Once STEP_WIN idle cycles have passed, the sequence is abandoned.
- R9: Inside an open window, command patterns are ordinary data. They are permitted up to the page limit and start no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; the only clear of the protection flag |
| rstN | input | 1 | Functional reset, active low, asynchronous; clears the sequence and window state |
| wrStb | input | 1 | Qualified write strobe, one cycle per byte write |
| wrAddr | input | 15 | Write address |
| wrData | input | 8 | Write data |
| loadDone | input | 1 | Pulse: the page load and its programming cycle have ended |
| wrPermit | output | 1 | The strobe in this cycle may reach the page buffer |
| protOn | output | 1 | Protection flag |

## Verification
`wrPermit` is a combinational result of the strobe, so it is due in the same cycle as `wrStb`. `protOn` changes on the clock edge that ends the third arming write or the `loadDone` cycle, so it is due one cycle later. The bench drives every input on the falling edge and samples both outputs 1 ns after that edge. It compares `protOn` with the model state before it applies the cycle, and compares `wrPermit` with the result the model gives for the cycle just driven. Directed runs probe the step-gap boundary at STEP_WIN-1 and STEP_WIN idle cycles, the page limit, interrupted sequences and both resets. A long seeded random run then covers the remaining interleavings.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_HI = 15'h5555;
  localparam logic [ADDR_W-1:0] ADR_LO = 15'h2AAA;

  localparam logic [DATA_W-1:0] D_KEY1   = 8'hAA;
  localparam logic [DATA_W-1:0] D_KEY2   = 8'h55;
  localparam logic [DATA_W-1:0] D_ARM    = 8'hA0;
  localparam logic [DATA_W-1:0] D_ESC    = 8'h80;
  localparam logic [DATA_W-1:0] D_DISARM = 8'h20;

  // pattern hits decoded by the datapath
  typedef struct packed {
    logic key1;
    logic key2;
    logic arm;
    logic esc;
    logic disarm;
  } cmdHit_t;

  // strobes from control to the flag register
  typedef struct packed {
    logic setProt;
    logic clrProt;
  } protStrb_t;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_K1, SEQ_K2, SEQ_ESC, SEQ_ESC_K1, SEQ_ESC_K2
  } seqState_t;
endpackage

// File: rtl/wps_match.sv
module wps_match
  import wps_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  protStrb_t         strb,
  output cmdHit_t           hit,
  output logic              protOn
);
  logic atHi, atLo;

  assign atHi       = (wrAddr == ADR_HI);
  assign atLo       = (wrAddr == ADR_LO);
  assign hit.key1   = atHi && (wrData == D_KEY1);
  assign hit.key2   = atLo && (wrData == D_KEY2);
  assign hit.arm    = atHi && (wrData == D_ARM);
  assign hit.esc    = atHi && (wrData == D_ESC);
  assign hit.disarm = atHi && (wrData == D_DISARM);

  // models a nonvolatile bit: only power-on clears it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             protOn <= 1'b0;
    else if (strb.setProt) protOn <= 1'b1;
    else if (strb.clrProt) protOn <= 1'b0;
  end

  // R2
  arm_code_chk: assert property (@(posedge clk) disable iff (!porN)
    strb.setProt |-> (wrAddr == 15'h5555 && wrData == 8'hA0));

  // R6
  prot_strb_excl_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({strb.setProt, strb.clrProt}));
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int STEP_WIN   = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStb,
  input  logic      loadDone,
  input  cmdHit_t   hit,
  input  logic      protOn,
  output protStrb_t strb,
  output logic      wrPermit
);
  localparam int TW = $clog2(STEP_WIN + 1);
  localparam int CW = $clog2(PAGE_BYTES + 1);

  seqState_t       seq, nextSeq;
  logic [TW-1:0]   tmr;
  logic [CW-1:0]   loadCnt;
  logic            winOpen, clrPend;
  logic            stepHit, armHit, disarmHit, pageRoom;

  always_comb begin
    stepHit = 1'b0;
    nextSeq = SEQ_IDLE;
    case (seq)
      SEQ_IDLE:   begin stepHit = hit.key1; nextSeq = SEQ_K1; end
      SEQ_K1:     begin stepHit = hit.key2; nextSeq = SEQ_K2; end
      SEQ_K2: begin
        stepHit = hit.arm || hit.esc;
        nextSeq = hit.esc ? SEQ_ESC : SEQ_IDLE;
      end
      SEQ_ESC:    begin stepHit = hit.key1; nextSeq = SEQ_ESC_K1; end
      SEQ_ESC_K1: begin stepHit = hit.key2; nextSeq = SEQ_ESC_K2; end
      SEQ_ESC_K2: begin stepHit = hit.disarm; nextSeq = SEQ_IDLE; end
      default:    begin stepHit = 1'b0; nextSeq = SEQ_IDLE; end
    endcase
  end

  assign armHit       = (seq == SEQ_K2) && hit.arm;
  assign disarmHit    = (seq == SEQ_ESC_K2) && hit.disarm;
  assign pageRoom     = (loadCnt < CW'(PAGE_BYTES));
  assign strb.setProt = wrStb && !winOpen && armHit;
  assign strb.clrProt = loadDone && clrPend && !strb.setProt;
  assign wrPermit     = wrStb && (winOpen ? pageRoom : (!stepHit && !protOn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq     <= SEQ_IDLE;
      tmr     <= '0;
      loadCnt <= '0;
      winOpen <= 1'b0;
      clrPend <= 1'b0;
    end else begin
      if (strb.clrProt) clrPend <= 1'b0;
      if (winOpen) begin
        seq <= SEQ_IDLE;
        if (wrStb && pageRoom) loadCnt <= loadCnt + 1'b1;
        if (loadDone) begin
          winOpen <= 1'b0;
          loadCnt <= '0;
        end
      end else if (wrStb) begin
        if (stepHit) begin
          seq <= nextSeq;
          tmr <= TW'(STEP_WIN);
          if (armHit) begin
            winOpen <= 1'b1;
            loadCnt <= '0;
            clrPend <= 1'b0;
          end
          if (disarmHit) clrPend <= 1'b1;
        end else begin
          seq <= SEQ_IDLE;
        end
      end else if (seq != SEQ_IDLE) begin
        tmr <= tmr - 1'b1;
        if (tmr == TW'(1)) seq <= SEQ_IDLE;
      end
    end
  end

  // R1
  permit_needs_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> wrStb);

  // R5
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && !winOpen) |-> !wrPermit);

  // R3
  page_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt <= CW'(PAGE_BYTES));

  // R2
  arm_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setProt |=> (winOpen && protOn));

  // R6
  clear_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protOn) |-> $past(loadDone));
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wps_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int STEP_WIN   = 64
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic [14:0] wrAddr,
  input  logic [7:0]  wrData,
  input  logic        loadDone,
  output logic        wrPermit,
  output logic        protOn
);
  cmdHit_t   hit;
  protStrb_t strb;

  wps_match u_match (
    .clk    (clk),
    .porN   (porN),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb),
    .hit    (hit),
    .protOn (protOn)
  );

  wps_ctrl #(.PAGE_BYTES(PAGE_BYTES), .STEP_WIN(STEP_WIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .loadDone (loadDone),
    .hit      (hit),
    .protOn   (protOn),
    .strb     (strb),
    .wrPermit (wrPermit)
  );
endmodule

// File: tb/sim_wprot_seq.sv
`timescale 1ns/1ps
module sim_wprot_seq;
  localparam int PB = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0;
  logic wrStb = 1'b0, loadDone = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic wrPermit, protOn;

  int nChk = 0, nBad = 0;

  // reference model state
  int mStep = 0, mAge = 0, mCnt = 0;
  bit mProt = 0, mWin = 0, mPend = 0;

  always #2 clk = ~clk;

  wprot_seq #(.PAGE_BYTES(PB), .STEP_WIN(SW)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .loadDone(loadDone), .wrPermit(wrPermit), .protOn(protOn)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit stb, input logic [14:0] a, input logic [7:0] d,
                           input bit done, output bit perm);
    bit k1, k2, arm, esc, dis, hit, armNow, disNow, doneClr;
    k1  = stb && a == 15'h5555 && d == 8'hAA;
    k2  = stb && a == 15'h2AAA && d == 8'h55;
    arm = stb && a == 15'h5555 && d == 8'hA0;
    esc = stb && a == 15'h5555 && d == 8'h80;
    dis = stb && a == 15'h5555 && d == 8'h20;
    case (mStep)
      0, 3:    hit = k1;
      1, 4:    hit = k2;
      2:       hit = arm || esc;
      default: hit = dis;
    endcase
    armNow  = !mWin && mStep == 2 && arm;
    disNow  = !mWin && mStep == 5 && dis;
    doneClr = done && mPend && !armNow;
    perm = 0;
    if (mWin) begin
      if (stb) begin
        perm = (mCnt < PB);
        if (perm) mCnt++;
      end
      if (done) begin mWin = 0; mCnt = 0; end
      mStep = 0;
    end else if (stb) begin
      if (hit) begin
        mAge = 0;
        if (armNow) begin mProt = 1; mWin = 1; mCnt = 0; mPend = 0; mStep = 0; end
        else if (disNow) begin mPend = 1; mStep = 0; end
        else mStep = mStep + 1;
      end else begin
        perm = !mProt;
        mStep = 0;
      end
    end else if (mStep != 0) begin
      mAge++;
      if (mAge >= SW) mStep = 0;
    end
    if (doneClr) begin
      mProt = 0;
      if (!disNow) mPend = 0;
    end
  endtask

  task automatic cyc(input bit stb, input logic [14:0] a, input logic [7:0] d,
                     input bit done, input string tag);
    bit ep;
    @(negedge clk);
    wrStb = stb; wrAddr = a; wrData = d; loadDone = done;
    #1;
    check(tag, "protOn", protOn, mProt);
    modelStep(stb, a, d, done, ep);
    check(tag, "wrPermit", wrPermit, ep);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 15'h0, 8'h0, 1'b0, tag);
  endtask

  task automatic done1(input string tag);
    cyc(1'b0, 15'h0, 8'h0, 1'b1, tag);
  endtask

  task automatic doReset(input bit por);
    @(negedge clk);
    wrStb = 0; loadDone = 0; rstN = 0;
    if (por) porN = 0;
    repeat (2) @(negedge clk);
    rstN = 1; porN = 1;
    mStep = 0; mAge = 0; mCnt = 0; mWin = 0; mPend = 0;
    if (por) mProt = 0;
  endtask

  task automatic armSeq(input string tag);
    wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'hA0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    porN = 1; rstN = 1;
    // R1 reset state and open writes
    idle(1, "R1");
    wr(15'h0123, 8'h5A, "R1");
    wr(15'h5555, 8'h12, "R1");
    idle(1, "R1");
    // R2 arm from unprotected, R3 page limit, R9 command data inside window
    armSeq("R2");
    idle(1, "R2");
    wr(15'h5555, 8'hAA, "R9");
    wr(15'h2AAA, 8'h55, "R9");
    wr(15'h0100, 8'h01, "R3");
    wr(15'h0101, 8'h02, "R3");
    wr(15'h0102, 8'h03, "R3");
    idle(1, "R3");
    // R4 close window, protection remains
    done1("R4");
    idle(1, "R4");
    wr(15'h0200, 8'h33, "R4");
    // R5 interrupted sequence under protection
    wr(15'h5555, 8'hAA, "R5");
    wr(15'h2AAA, 8'h55, "R5");
    wr(15'h5555, 8'h12, "R5");
    wr(15'h5555, 8'hA0, "R5");
    wr(15'h0300, 8'h44, "R5");
    idle(2, "R5");
    // R7 functional reset keeps the flag
    doReset(1'b0);
    idle(1, "R7");
    wr(15'h0301, 8'h45, "R7");
    // R8 gap too long, then gap at the limit
    wr(15'h5555, 8'hAA, "R8");
    wr(15'h2AAA, 8'h55, "R8");
    idle(SW, "R8");
    wr(15'h5555, 8'hA0, "R8");
    wr(15'h0400, 8'h66, "R8");
    wr(15'h5555, 8'hAA, "R8");
    wr(15'h2AAA, 8'h55, "R8");
    idle(SW - 1, "R8");
    wr(15'h5555, 8'hA0, "R8");
    wr(15'h0401, 8'h67, "R8");
    done1("R8");
    idle(1, "R8");
    // R6 disarm sequence
    wr(15'h5555, 8'hAA, "R6"); wr(15'h2AAA, 8'h55, "R6"); wr(15'h5555, 8'h80, "R6");
    wr(15'h5555, 8'hAA, "R6"); wr(15'h2AAA, 8'h55, "R6"); wr(15'h5555, 8'h20, "R6");
    wr(15'h0500, 8'h77, "R6");
    idle(3, "R6");
    done1("R6");
    idle(1, "R6");
    wr(15'h0501, 8'h78, "R6");
    // R1 aborted sequence in open mode
    wr(15'h5555, 8'hAA, "R1");
    wr(15'h1234, 8'h33, "R1");
    idle(1, "R1");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [14:0] a;
      logic [7:0]  d;
      int ra, rd;
      ra = $urandom % 3;
      rd = $urandom % 6;
      a = (ra == 0) ? 15'h5555 : (ra == 1) ? 15'h2AAA : 15'($urandom);
      case (rd)
        0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0;
        3: d = 8'h80; 4: d = 8'h20; default: d = 8'($urandom);
      endcase
      cyc(($urandom % 4) != 0, a, d, ($urandom % 40) == 0, "R5");
    end
    // R1 power-on clears the flag
    armSeq("R1");
    doReset(1'b1);
    idle(1, "R1");
    wr(15'h0600, 8'h11, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule